// File: doc/BRIEF.md
# SAR Conversion Controller with Tagged Output

This block runs one successive-approximation conversion each time a host strobes a conversion-start line. After the strobe it holds an acquisition interval of a programmable number of clock cycles. It then tests one result bit per clock, MSB first. For each bit it presents a trial code to an external DAC and reads back a one-bit comparator decision. A ready line stays low from the accepted strobe until the result is valid.

When the result is valid, it goes into an output word together with a tag. The tag records the channel configuration that was captured at the strobe: the differential flag and the mux address. In bipolar mode the data field is converted to two's complement. The word is held until the next conversion completes. It is driven onto the bus only while both chip select and read are low; a drive-enable output controls the pad tristates.

With the shutdown line low, the chip-select line chooses between two power-down depths. Chip select low gives a light nap and chip select high gives a deep sleep. A shutdown request never interrupts a running conversion.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `rdy` is 1, `nap` and `sleep` are 0, `dbus_oe` is 0, and the held output word is all zeros.
- R2: A conversion is accepted on a clock edge that samples `convst_n` low when the previous sample was high, but only while `cs_n` is low and `shdn_n` is high. A falling edge on `convst_n` while `cs_n` is high starts nothing and `rdy` stays 1.
- R3: `rdy` falls on the clock edge that accepts a conversion. It stays low for exactly ACQ_CYC + NBITS clock cycles and then rises.
- R4: The bits are decided MSB first, one per clock. A bit is kept when `cmp_in` is 1 while `dac_code` presents the trial code. With `cmp_in` = (input >= `dac_code`), the raw result equals the input code.
- R5: Falling edges on `convst_n` during a running conversion are ignored: the busy length and the result are unchanged.
- R6: The output word is laid out as follows: bit 15 is the differential flag, bits 14:12 are the mux address, and bits 11:0 are the data. The configuration is captured on the accepted edge, so changes to it during the conversion have no effect on the word.
- R7: In unipolar mode (`cfg_bipolar` = 0) the data field is straight binary. In bipolar mode the MSB of the raw result is inverted, which gives two's complement.
- R8: `dbus_oe` is 1 and `dbus` carries the held word only while `cs_n` and `rd_n` are both low. Otherwise `dbus_oe` is 0 and `dbus` is 0.
- R9: While idle, with `shdn_n` low, the next clock edge sets `nap` = 1 if `cs_n` is low and `sleep` = 1 if `cs_n` is high. Both are never 1 together. No conversion starts while `shdn_n` is low. Raising `shdn_n` clears both on the next edge.
- R10: A shutdown request made during a conversion does not abort it. `nap` and `sleep` stay 0 while `rdy` is low and take effect one cycle after `rdy` rises.
- R11: The held word does not change between conversions, whatever reads or configuration changes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; also picks the shutdown depth |
| convst_n | input | 1 | Conversion start; a falling edge requests a conversion |
| rd_n | input | 1 | Read strobe, active low |
| shdn_n | input | 1 | Shutdown request, active low |
| cfg_diff | input | 1 | Differential flag of the channel configuration |
| cfg_addr | input | ADDR_W | Mux address of the channel configuration |
| cfg_bipolar | input | 1 | 1 selects the two's-complement result format |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| dac_code | output | NBITS | Trial code for the DAC; 0 outside the bit-decision phase |
| rdy | output | 1 | Low while acquiring and converting |
| nap | output | 1 | Light power-down active |
| sleep | output | 1 | Deep power-down active |
| dbus | output | NBITS+ADDR_W+1 | Output word while enabled, else 0 |
| dbus_oe | output | 1 | Drive enable for the bus pad tristates |

## Verification
The bench builds the block with NBITS = 12, ADDR_W = 3 and ACQ_CYC = 4. With these values each conversion takes a known 16 cycles, which is short enough to run a whole vector table and several perturbed conversions. Twelve bits bring the data-format boundaries into play: all zeros, all ones, and the 0x7FF/0x800 pair where the bipolar MSB inversion flips the sign. The comparator is modelled as a live compare against a bench-held input code, so every binary-search path is exercised.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2
    } sar_st_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int NBITS   = 12,
    parameter int ADDR_W  = 3,
    parameter int ACQ_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              convst_n,
    input  logic              shdn_n,
    input  logic              cfg_diff,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_bipolar,
    input  logic              cmp_in,
    output logic [NBITS-1:0]  dac_code,
    output logic              rdy,
    output logic              nap,
    output logic              sleep,
    output logic              load,
    output logic [NBITS-1:0]  fin_data,
    output logic              cap_diff,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_bip
);
    localparam int CNT_W = (ACQ_CYC < 2) ? 1 : $clog2(ACQ_CYC);
    localparam int IDX_W = (NBITS < 2) ? 1 : $clog2(NBITS);

    typedef struct packed {
        sar_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [NBITS-1:0]  sar;
        logic              conv_prev;
        logic              rdy;
        logic              nap;
        logic              sleep;
        logic              diff;
        logic [ADDR_W-1:0] addr;
        logic              bip;
    } seq_t;

    seq_t q, n;
    logic start;
    logic [NBITS-1:0] trial;

    assign start = (q.st == ST_IDLE) && shdn_n && !cs_n && q.conv_prev && !convst_n;

    always_comb begin
        n           = q;
        n.conv_prev = convst_n;
        n.nap       = 1'b0;
        n.sleep     = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                n.nap   = !shdn_n && !cs_n;
                n.sleep = !shdn_n && cs_n;
                if (start) begin
                    n.st   = ST_ACQ;
                    n.cnt  = CNT_W'(ACQ_CYC - 1);
                    n.rdy  = 1'b0;
                    n.sar  = '0;
                    n.diff = cfg_diff;
                    n.addr = cfg_addr;
                    n.bip  = cfg_bipolar;
                end
            end
            ST_ACQ: begin
                if (q.cnt == '0) begin
                    n.st  = ST_CONV;
                    n.idx = IDX_W'(NBITS - 1);
                end else begin
                    n.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_CONV: begin
                n.sar[q.idx] = cmp_in;
                if (q.idx == '0) begin
                    n.st  = ST_IDLE;
                    n.rdy = 1'b1;
                end else begin
                    n.idx = q.idx - IDX_W'(1);
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= ST_IDLE;
            q.conv_prev <= 1'b1;
            q.rdy       <= 1'b1;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        trial        = q.sar;
        trial[q.idx] = 1'b1;
    end

    assign dac_code = (q.st == ST_CONV) ? trial : '0;
    assign rdy      = q.rdy;
    assign nap      = q.nap;
    assign sleep    = q.sleep;
    assign load     = (q.st == ST_CONV) && (q.idx == '0);
    assign fin_data = n.sar;
    assign cap_diff = q.diff;
    assign cap_addr = q.addr;
    assign cap_bip  = q.bip;

    // R2: an accepted strobe drops ready on the following cycle
    p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_IDLE) && shdn_n && !cs_n && q.conv_prev && !convst_n) |=> !rdy);

    // R3: acquisition is not cut short
    p_acq_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_ACQ) && (q.cnt != '0)) |=> (q.st == ST_ACQ));

    // R5: bit decisions step down one per clock, no restart
    p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_CONV) && (q.idx != '0)) |=>
            ((q.st == ST_CONV) && (q.idx == $past(q.idx) - IDX_W'(1))));

    // R9: at most one power-down depth
    p_one_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nap, sleep}));

    // R10: power-down only when not busy
    p_power_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nap || sleep) |-> rdy);
endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch #(
    parameter int NBITS  = 12,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NBITS-1:0]         fin_data,
    input  logic                     cap_diff,
    input  logic [ADDR_W-1:0]        cap_addr,
    input  logic                     cap_bip,
    input  logic                     cs_n,
    input  logic                     rd_n,
    output logic [NBITS+ADDR_W:0]    dbus,
    output logic                     dbus_oe
);
    localparam int WORD_W = NBITS + ADDR_W + 1;

    logic [WORD_W-1:0] word_d, word_q;
    logic [NBITS-1:0]  fmt;

    always_comb begin
        fmt = fin_data;
        if (cap_bip) fmt[NBITS-1] = ~fin_data[NBITS-1];
        word_d = load ? {cap_diff, cap_addr, fmt} : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign dbus_oe = !cs_n && !rd_n;
    assign dbus    = dbus_oe ? word_q : '0;

    // R11: the held word changes only on a completed conversion
    p_word_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(word_q));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
    parameter int NBITS   = 12,
    parameter int ADDR_W  = 3,
    parameter int ACQ_CYC = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  convst_n,
    input  logic                  rd_n,
    input  logic                  shdn_n,
    input  logic                  cfg_diff,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic                  cfg_bipolar,
    input  logic                  cmp_in,
    output logic [NBITS-1:0]      dac_code,
    output logic                  rdy,
    output logic                  nap,
    output logic                  sleep,
    output logic [NBITS+ADDR_W:0] dbus,
    output logic                  dbus_oe
);
    logic              load;
    logic [NBITS-1:0]  fin_data;
    logic              cap_diff;
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_bip;

    sar_seq #(.NBITS(NBITS), .ADDR_W(ADDR_W), .ACQ_CYC(ACQ_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .convst_n(convst_n), .shdn_n(shdn_n),
        .cfg_diff(cfg_diff), .cfg_addr(cfg_addr), .cfg_bipolar(cfg_bipolar),
        .cmp_in(cmp_in), .dac_code(dac_code), .rdy(rdy), .nap(nap), .sleep(sleep),
        .load(load), .fin_data(fin_data), .cap_diff(cap_diff), .cap_addr(cap_addr),
        .cap_bip(cap_bip)
    );

    sar_out_latch #(.NBITS(NBITS), .ADDR_W(ADDR_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(load), .fin_data(fin_data),
        .cap_diff(cap_diff), .cap_addr(cap_addr), .cap_bip(cap_bip),
        .cs_n(cs_n), .rd_n(rd_n), .dbus(dbus), .dbus_oe(dbus_oe)
    );

    // R8: drive enable follows select and read only
    p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> !dbus_oe);
endmodule

// File: tb/sar_conv_ctrl_bench.sv
`timescale 1ns/1ps
module sar_conv_ctrl_bench;
    localparam int NB  = 12;
    localparam int AW  = 3;
    localparam int ACQ = 4;
    localparam int WW  = NB + AW + 1;
    localparam int BUSY_LEN = ACQ + NB;

    // vector: {input code, diff, addr, bipolar}
    localparam logic [16:0] VEC [0:7] = '{
        {12'h000, 1'b0, 3'd0, 1'b0},
        {12'hFFF, 1'b1, 3'd7, 1'b0},
        {12'h800, 1'b0, 3'd3, 1'b1},
        {12'h7FF, 1'b1, 3'd5, 1'b1},
        {12'h555, 1'b0, 3'd6, 1'b0},
        {12'hAAA, 1'b1, 3'd2, 1'b1},
        {12'h001, 1'b0, 3'd1, 1'b0},
        {12'hFFE, 1'b1, 3'd4, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, convst_n = 1'b1, rd_n = 1'b1, shdn_n = 1'b1;
    logic cfg_diff = 1'b0, cfg_bipolar = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [NB-1:0] vin = '0;
    logic cmp_in;
    logic [NB-1:0] dac_code;
    logic rdy, nap, sleep, dbus_oe;
    logic [WW-1:0] dbus;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;
    assign cmp_in = (vin >= dac_code);

    sar_conv_ctrl #(.NBITS(NB), .ADDR_W(AW), .ACQ_CYC(ACQ)) u_sar_conv_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .convst_n(convst_n), .rd_n(rd_n),
        .shdn_n(shdn_n), .cfg_diff(cfg_diff), .cfg_addr(cfg_addr),
        .cfg_bipolar(cfg_bipolar), .cmp_in(cmp_in), .dac_code(dac_code),
        .rdy(rdy), .nap(nap), .sleep(sleep), .dbus(dbus), .dbus_oe(dbus_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] exp_word(input logic [NB-1:0] v, input logic d,
                                               input logic [AW-1:0] a, input logic b);
        logic [NB-1:0] f;
        f = v;
        if (b) f[NB-1] = ~v[NB-1];
        return {d, a, f};
    endfunction

    task automatic read_word(output logic [WW-1:0] w, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        #2;
        w = dbus; oe = dbus_oe;
        rd_n = 1'b1;
    endtask

    // one conversion; returns number of sampled cycles with rdy low
    task automatic convert(input logic [NB-1:0] v, input logic d, input logic [AW-1:0] a,
                           input logic b, input bit perturb, input bit shdn_mid,
                           output int low, output bit nap_seen);
        int guard;
        @(negedge clk);
        vin = v; cfg_diff = d; cfg_addr = a; cfg_bipolar = b;
        cs_n = 1'b0; convst_n = 1'b0;
        low = 0; guard = 0; nap_seen = 0;
        @(negedge clk);
        while (rdy == 1'b0 && guard < 100) begin
            low++; guard++;
            if (nap || sleep) nap_seen = 1;
            if (low == 1) convst_n = 1'b1;
            if (low == 3 && perturb) begin
                convst_n = 1'b0; cfg_diff = ~d; cfg_addr = ~a; cfg_bipolar = ~b;
            end
            if (low == 3 && shdn_mid) shdn_n = 1'b0;
            if (low == 4) convst_n = 1'b1;
            @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [WW-1:0] w, w2;
        logic oe;
        int low;
        bit ns;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rdy", {31'd0, rdy}, 32'd1);
        chk("R1 nap", {31'd0, nap}, 32'd0);
        chk("R1 sleep", {31'd0, sleep}, 32'd0);
        chk("R1 oe", {31'd0, dbus_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        read_word(w, oe);
        chk("R1 word", {16'd0, w}, 32'd0);

        // R8 bus gating
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #2;
        chk("R8 cs high oe", {31'd0, dbus_oe}, 32'd0);
        chk("R8 cs high bus", {16'd0, dbus}, 32'd0);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; #2;
        chk("R8 rd high oe", {31'd0, dbus_oe}, 32'd0);

        // R2 no start with chip select high
        @(negedge clk); cs_n = 1'b1; convst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R2 ignored while cs high", {31'd0, rdy}, 32'd1);
        end
        convst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R6 R7 table
        for (int i = 0; i < 8; i++) begin
            logic [NB-1:0] v; logic d; logic [AW-1:0] a; logic b;
            {v, d, a, b} = VEC[i];
            convert(v, d, a, b, 1'b0, 1'b0, low, ns);
            chk("R3 busy length", low, BUSY_LEN);
            read_word(w, oe);
            chk("R8 oe when read", {31'd0, oe}, 32'd1);
            chk("R4 R6 R7 word", {16'd0, w}, {16'd0, exp_word(v, d, a, b)});
        end

        // R5 R6 perturbed conversion
        convert(12'h3C5, 1'b1, 3'd6, 1'b0, 1'b1, 1'b0, low, ns);
        chk("R5 busy not extended", low, BUSY_LEN);
        read_word(w, oe);
        chk("R5 R6 word from first strobe", {16'd0, w}, {16'd0, exp_word(12'h3C5, 1'b1, 3'd6, 1'b0)});
        @(negedge clk); #2;
        chk("R5 no second conversion", {31'd0, rdy}, 32'd1);

        // R11 hold
        @(negedge clk); vin = 12'h0F0; cfg_diff = 1'b0; cfg_addr = 3'd0; cfg_bipolar = 1'b1;
        repeat (4) @(negedge clk);
        read_word(w2, oe);
        chk("R11 word held", {16'd0, w2}, {16'd0, w});

        // R9 shutdown depths
        @(negedge clk); cs_n = 1'b0; shdn_n = 1'b0;
        @(negedge clk);
        chk("R9 nap", {31'd0, nap}, 32'd1);
        chk("R9 nap only", {31'd0, sleep}, 32'd0);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R9 sleep", {31'd0, sleep}, 32'd1);
        chk("R9 sleep only", {31'd0, nap}, 32'd0);
        cs_n = 1'b0; convst_n = 1'b0;
        @(negedge clk);
        chk("R9 no start in shutdown", {31'd0, rdy}, 32'd1);
        convst_n = 1'b1; shdn_n = 1'b1;
        @(negedge clk);
        chk("R9 wake", {30'd0, nap, sleep}, 32'd0);

        // R10 shutdown during conversion
        convert(12'h6A3, 1'b0, 3'd2, 1'b1, 1'b0, 1'b1, low, ns);
        chk("R10 not aborted", low, BUSY_LEN);
        chk("R10 no power-down while busy", {31'd0, ns}, 32'd0);
        chk("R10 nap not yet", {31'd0, nap}, 32'd0);
        @(negedge clk);
        chk("R10 nap after ready", {31'd0, nap}, 32'd1);
        shdn_n = 1'b1;
        read_word(w, oe);
        chk("R10 result intact", {16'd0, w}, {16'd0, exp_word(12'h6A3, 1'b0, 3'd2, 1'b1)});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule